// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single physical memory access may proceed. It receives the access's byte address, its size (1, 2, 4 or 8 bytes, naturally aligned), its kind (load, store or instruction fetch) and the privilege level it runs at. It also receives the complete set of protection entries as flat vectors. Each entry has an eight-bit configuration byte and an address register that counts 4-byte granules. The allow or deny verdict is registered and appears one clock after the request.

The access is split into 4-byte granules, and each granule is tested against every entry separately. The entry with the smallest index that covers at least one granule of the access is the only one consulted. If that entry covers only some of the granules, the access is refused regardless of the entry's permissions. A later entry that would cover the whole access does not rescue it.

The surrounding core uses the checker for data accesses, instruction fetches and page-table walks. A page-table read is presented as a supervisor load of 4 or 8 bytes, and an accessed/dirty update as a supervisor store of the same size.

Top module: `pmp_access_checker`

## Requirements
- R1: An access of size code s (0=1, 1=2, 2=4, 3=8 bytes) is divided into 4-byte granules. Sizes up to 4 bytes occupy the one granule holding the address. An 8-byte access occupies two consecutive granules starting at address bits [PA_W-1:3].
- R2: With address mode 1 (top-of-range) in configuration bits [4:3], a granule index g matches when the lower bound is at most g and g is strictly below the entry's address. The lower bound is the previous entry's address, or zero for entry 0.
- R3: With address mode 2 (single granule), a granule matches only its exact address. With mode 3 (power-of-two region), an address with k trailing ones covers 2^(k+1) granules, aligned to that size, around the address.
- R4: An entry with address mode 0 (off) never matches, whatever its address or permission bits.
- R5: Only the lowest-indexed entry that matches any granule of the access decides the verdict. Higher entries have no effect.
- R6: If the deciding entry matches some but not all granules of the access, the access is denied.
- R7: When the deciding entry covers the whole access and the privilege code is 3 (machine), the access is allowed if lock bit 7 is clear.
- R8: Otherwise the access is allowed only if the bit for its kind is set in the deciding entry: kind 0 (load) needs bit 0, kind 1 (store) needs bit 1, and kind 2 (fetch) needs bit 2. Privilege codes 0 and 1 (user and supervisor) always obey these bits.
- R9: When no entry matches any granule, machine-mode accesses are allowed and all other privilege levels are denied.
- R10: The verdict `allow_q` is registered. It reflects the request present at the previous rising clock edge and reads 0 while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | PA_W | Physical byte address of the access |
| req_size | input | 2 | Size code: log2 of the byte count |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| ent_cfg | input | N_ENTRIES*8 | Configuration bytes, entry i in bits [8i+7:8i] |
| ent_addr | input | N_ENTRIES*(PA_W-2) | Granule-address registers, entry i in slice i |
| allow_q | output | 1 | Registered verdict: 1 allow, 0 deny |

## Verification
Some properties are checked by the assertions on every cycle:
- entries that are switched off never report a hit;
- at most one entry is selected, and the selected entry is one that actually hit;
- the granule count follows the size code;
- a partial hit, a miss in a lower privilege level, a miss in machine mode and an unlocked machine-mode full hit each produce the expected verdict one cycle later.

Other behaviour can only be shown by the bench's scenarios, because it depends on the arithmetic of the matching itself:
- whether the top-of-range and power-of-two comparisons find the right boundaries;
- that a straddled single-granule or top-of-range entry blocks an access which a later entry would fully allow;
- that lock and permission bits map to the right kinds.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    localparam logic [1:0] PRIV_M = 2'd3;

    // configuration byte layout
    localparam int CFG_R     = 0;
    localparam int CFG_W     = 1;
    localparam int CFG_X     = 2;
    localparam int CFG_AM_LO = 3;
    localparam int CFG_LOCK  = 7;

    localparam int GRAN_SHIFT = 2;

    typedef struct packed {
        logic allow;
    } chk_state_t;

endpackage

// File: rtl/pmp_range_match.sv
module pmp_range_match
    import pmp_chk_pkg::*;
#(
    parameter int GA_W   = 32,
    parameter int N_GRAN = 2
) (
    input  logic [1:0]             mode,
    input  logic [GA_W-1:0]        lo_bound,
    input  logic [GA_W-1:0]        hi_addr,
    input  logic [N_GRAN*GA_W-1:0] gran_addr,
    input  logic [N_GRAN-1:0]      gran_valid,
    output logic                   any_hit,
    output logic                   all_hit
);

    logic [GA_W:0]     m_ext;
    logic [GA_W:0]     trail;
    logic [GA_W-1:0]   care;
    logic [N_GRAN-1:0] hit;

    // trailing ones of the extended address mark the don't-care bits
    always_comb begin
        m_ext = {hi_addr, (mode != AM_NA4)};
        trail = m_ext & ~(m_ext + (GA_W+1)'(1));
        care  = ~trail[GA_W-1:0];
    end

    for (genvar j = 0; j < N_GRAN; j++) begin : g_gran
        logic [GA_W-1:0] g;
        assign g = gran_addr[j*GA_W +: GA_W];
        always_comb begin
            unique case (mode)
                AM_TOR:           hit[j] = (g >= lo_bound) && (g < hi_addr);
                AM_NA4, AM_NAPOT: hit[j] = ((g ^ hi_addr) & care) == '0;
                default:          hit[j] = 1'b0;
            endcase
        end
    end

    assign any_hit = |(hit & gran_valid);
    assign all_hit = &(hit | ~gran_valid);

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
    import pmp_chk_pkg::*;
(
    input  logic [7:0] cfg,
    input  logic [1:0] kind,
    input  logic [1:0] priv,
    output logic       perm_ok
);

    always_comb begin
        perm_ok = (priv == PRIV_M) && !cfg[CFG_LOCK];
        unique case (kind)
            KIND_LOAD:  perm_ok = perm_ok || cfg[CFG_R];
            KIND_STORE: perm_ok = perm_ok || cfg[CFG_W];
            KIND_FETCH: perm_ok = perm_ok || cfg[CFG_X];
            default:    perm_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
    parameter int N = 16
) (
    input  logic [N-1:0] hits,
    output logic [N-1:0] sel,
    output logic         found
);

    // isolate the lowest set bit
    assign sel   = hits & ~(hits - N'(1));
    assign found = |hits;

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
    import pmp_chk_pkg::*;
#(
    parameter int N_ENTRIES     = 16,
    parameter int PA_W          = 34,
    parameter int MAX_SIZE_LOG2 = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PA_W-1:0]              req_addr,
    input  logic [1:0]                   req_size,
    input  logic [1:0]                   req_kind,
    input  logic [1:0]                   req_priv,
    input  logic [N_ENTRIES*8-1:0]       ent_cfg,
    input  logic [N_ENTRIES*(PA_W-GRAN_SHIFT)-1:0] ent_addr,
    output logic                         allow_q
);

    localparam int GA_W   = PA_W - GRAN_SHIFT;
    localparam int N_GRAN = (1 << MAX_SIZE_LOG2) >> GRAN_SHIFT;

    logic [GA_W-1:0]        gaddr;
    logic [N_GRAN*GA_W-1:0] gran_vec;
    logic [N_GRAN-1:0]      gran_valid;
    int unsigned            gran_cnt;

    always_comb begin
        gaddr    = req_addr[PA_W-1:GRAN_SHIFT];
        gran_cnt = (int'(req_size) > GRAN_SHIFT) ? (1 << (int'(req_size) - GRAN_SHIFT)) : 1;
        for (int j = 0; j < N_GRAN; j++) begin
            gran_valid[j] = (j < gran_cnt);
            gran_vec[j*GA_W +: GA_W] = (gaddr & ~GA_W'(gran_cnt - 1)) + GA_W'(j);
        end
    end

    logic [N_ENTRIES-1:0] hit_any, hit_all, perm_vec, lock_vec, sel_vec;
    logic                 found;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic [GA_W-1:0] lo;
        logic [7:0]      cfg_i;
        assign cfg_i       = ent_cfg[i*8 +: 8];
        assign lock_vec[i] = cfg_i[CFG_LOCK];
        if (i == 0) begin : g_lo0
            assign lo = '0;
        end else begin : g_lon
            assign lo = ent_addr[(i-1)*GA_W +: GA_W];
        end

        pmp_range_match #(.GA_W(GA_W), .N_GRAN(N_GRAN)) u_match (
            .mode       (cfg_i[CFG_AM_LO +: 2]),
            .lo_bound   (lo),
            .hi_addr    (ent_addr[i*GA_W +: GA_W]),
            .gran_addr  (gran_vec),
            .gran_valid (gran_valid),
            .any_hit    (hit_any[i]),
            .all_hit    (hit_all[i])
        );

        pmp_perm_eval u_perm (
            .cfg     (cfg_i),
            .kind    (req_kind),
            .priv    (req_priv),
            .perm_ok (perm_vec[i])
        );

        assert_off_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i[CFG_AM_LO +: 2] == AM_OFF) |-> !hit_any[i]);
    end

    pmp_first_hit #(.N(N_ENTRIES)) u_pick (
        .hits  (hit_any),
        .sel   (sel_vec),
        .found (found)
    );

    logic sel_full, sel_perm, sel_lock;
    chk_state_t st_d, st_q;

    always_comb begin
        sel_full = |(sel_vec & hit_all);
        sel_perm = |(sel_vec & perm_vec);
        sel_lock = |(sel_vec & lock_vec);
        st_d     = st_q;
        if (found) st_d.allow = sel_full && sel_perm;
        else       st_d.allow = (req_priv == PRIV_M);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign allow_q = st_q.allow;

    assert_granule_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_size) <= GRAN_SHIFT) |-> ($countones(gran_valid) == 1));
    assert_single_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec) && (found == (sel_vec != '0)) && ((sel_vec & ~hit_any) == '0));
    assert_partial_denies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !sel_full) |=> !allow_q);
    assert_machine_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (found && sel_full && req_priv == PRIV_M && !sel_lock && req_kind != KIND_RSVD) |=> allow_q);
    assert_miss_lowpriv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!found && req_priv != PRIV_M) |=> !allow_q);
    assert_miss_machine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!found && req_priv == PRIV_M) |=> allow_q);

endmodule

// File: tb/pmp_access_checker_test.sv
module pmp_access_checker_test;

    localparam int NE   = 4;
    localparam int PA_W = 12;
    localparam int GA_W = PA_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PA_W-1:0]   req_addr = '0;
    logic [1:0]        req_size = '0, req_kind = '0, req_priv = 2'd3;
    logic [NE*8-1:0]   ent_cfg = '0;
    logic [NE*GA_W-1:0] ent_addr = '0;
    logic              allow_q;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    int cfg_b [NE];
    int adr_b [NE];

    always #4 clk = ~clk;

    pmp_access_checker #(.N_ENTRIES(NE), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_size(req_size),
        .req_kind(req_kind), .req_priv(req_priv), .ent_cfg(ent_cfg),
        .ent_addr(ent_addr), .allow_q(allow_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual=%0d expected=done", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit ent_hit(int e, int g);
        int mode = (cfg_b[e] >> 3) & 3;
        int a = adr_b[e];
        int lo = (e == 0) ? 0 : adr_b[e-1];
        int k = 0;
        int span, base;
        case (mode)
            1: return (lo <= g) && (g < a);
            2: return g == a;
            3: begin
                while (k < GA_W && ((a >> k) & 1) == 1) k++;
                span = 1 << (k + 1);
                base = (a / span) * span;
                return (g >= base) && (g < base + span);
            end
            default: return 0;
        endcase
    endfunction

    function automatic bit model(int ba, int sz, int kind, int priv, output string tag);
        int first = ba / 4;
        int last  = (ba + (1 << sz) - 1) / 4;
        for (int e = 0; e < NE; e++) begin
            bit anyh = 0, allh = 1;
            for (int g = first; g <= last; g++) begin
                bit h = ent_hit(e, g);
                anyh |= h;
                allh &= h;
            end
            if (anyh) begin
                if (!allh) begin tag = "R6"; return 0; end
                if (priv == 3 && ((cfg_b[e] >> 7) & 1) == 0) begin tag = "R7"; return 1; end
                tag = "R8";
                return ((cfg_b[e] >> kind) & 1) == 1;
            end
        end
        tag = "R9";
        return priv == 3;
    endfunction

    task automatic load_cfg();
        @(negedge clk);
        for (int e = 0; e < NE; e++) begin
            ent_cfg[e*8 +: 8]        = 8'(cfg_b[e]);
            ent_addr[e*GA_W +: GA_W] = GA_W'(adr_b[e]);
        end
    endtask

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b addr=%0d size=%0d kind=%0d priv=%0d",
                     tag, act, exp, req_addr, req_size, req_kind, req_priv);
        end
    endtask

    // drive, let the register capture, sample one time unit after the edge
    task automatic probe(int ba, int sz, int kind, int priv, string tag, bit exp);
        @(negedge clk);
        req_addr = PA_W'(ba); req_size = 2'(sz); req_kind = 2'(kind); req_priv = 2'(priv);
        @(posedge clk); #1;
        check(tag, allow_q, exp);
    endtask

    task automatic sweep();
        string tag;
        bit exp;
        for (int sz = 0; sz < 4; sz++)
            for (int ba = 0; ba < 256; ba += (1 << sz))
                for (int kind = 0; kind < 3; kind++)
                    for (int pi = 0; pi < 3; pi++) begin
                        int priv = (pi == 2) ? 3 : pi;
                        exp = model(ba, sz, kind, priv, tag);
                        probe(ba, sz, kind, priv, tag, exp);
                    end
    endtask

    initial begin
        // R10: reset holds the verdict low even for an allowable machine-mode miss
        req_addr = 12'd2048; req_size = 2'd2; req_kind = 2'd0; req_priv = 2'd3;
        repeat (3) @(posedge clk);
        #1 check("R10", allow_q, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R10", allow_q, 1'b0);
        @(posedge clk); #1;
        check("R10", allow_q, 1'b1);

        // configuration A
        cfg_b[0] = 8'h19; adr_b[0] = 11;   // NAPOT granules 8..15, R
        cfg_b[1] = 8'h8B; adr_b[1] = 21;   // TOR granules 11..20, RW, locked
        cfg_b[2] = 8'h14; adr_b[2] = 30;   // NA4 granule 30, X
        cfg_b[3] = 8'h9F; adr_b[3] = 31;   // NAPOT granules 0..63, RWX, locked
        load_cfg();
        probe(32, 2, 0, 1, "R3", 1'b1);    // R3 NAPOT load
        probe(32, 2, 1, 1, "R5", 1'b0);    // R5 entry 0 decides, entry 3 ignored
        probe(48, 3, 1, 1, "R5", 1'b0);    // R5 entry 0 overlaps entry 1
        probe(68, 2, 1, 1, "R2", 1'b1);    // R2 TOR store
        probe(84, 2, 1, 1, "R2", 1'b1);    // R2 TOR upper bound excluded, entry 3 decides
        probe(68, 2, 2, 3, "R8", 1'b0);    // R8 locked entry binds machine mode
        probe(36, 2, 1, 3, "R7", 1'b1);    // R7 unlocked machine store
        probe(120, 3, 0, 3, "R6", 1'b0);   // R6 8-byte access straddling NA4 granule
        probe(80, 3, 0, 1, "R6", 1'b0);    // R6 straddling TOR end, entry 3 would allow
        probe(124, 2, 0, 1, "R1", 1'b1);   // R1 4-byte access stays in one granule
        probe(121, 0, 2, 0, "R3", 1'b1);   // R3 NA4 fetch
        probe(300, 2, 0, 1, "R9", 1'b0);   // R9 miss in supervisor
        probe(300, 2, 0, 3, "R9", 1'b1);   // R9 miss in machine
        sweep();

        // configuration B: off entries carry permissive bits and covering addresses
        cfg_b[0] = 8'h0D; adr_b[0] = 4;    // TOR granules 0..3, RX
        cfg_b[1] = 8'h07; adr_b[1] = 40;   // off
        cfg_b[2] = 8'h07; adr_b[2] = 25;   // off
        cfg_b[3] = 8'h07; adr_b[3] = 63;   // off
        load_cfg();
        probe(100, 2, 0, 1, "R4", 1'b0);   // R4 off entries do not match
        probe(8, 2, 1, 3, "R7", 1'b1);     // R7 unlocked, no W, machine store
        probe(8, 2, 1, 0, "R8", 1'b0);     // R8 user store without W
        sweep();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule